// File: doc/BRIEF.md
# Flag-Setting Integer ALU Datapath

This block is the single-cycle integer execute stage of a 32-bit processor pipeline. Each cycle it takes an opcode, a base operand and a second operand that is already shifted or immediate. It returns the arithmetic or logical result together with a write-enable. It also keeps the four condition flags (negative, zero, carry, overflow) in a register that changes only when an instruction asks for it.

The carry flag feeds the add-with-carry and subtract-with-carry operations, so a sequence of instructions can chain 64-bit or 96-bit arithmetic. The unit also covers the cases where the program counter is an operand:

- A program-counter base is aligned to a word before use.
- A result that goes to the program counter leaves as a branch target with bit 0 cleared, together with a branch strobe.
- A combination that is not allowed raises an error and does not execute.

An external condition-pass input suppresses the whole operation when the instruction's condition fails.

Top module: `int_exec_unit`

## Requirements
- R1: Opcode encoding on `op_i`: 0 ADD (A+B), 1 ADC (A+B+C), 2 SUB (A-B), 3 SBC (A-B-(1-C)), 5 AND, 6 ORR, 7 EOR, 8 BIC (A AND NOT B), 9 ORN (A OR NOT B). `res_o` carries the 32-bit result of the selected operation.
- R2: Opcode 4 (RSB) computes B minus A.
- R3: After a flag-setting arithmetic operation, C is the carry out of the addition. For SUB, SBC and RSB, C is NOT borrow. V is set on signed 32-bit overflow.
- R4: After a flag-setting operation, N equals result bit 31 and Z is 1 exactly when all 32 result bits are zero. `flags_o` is {N,Z,C,V}, with N at bit 3 and V at bit 0.
- R5: Flags are written on the clock edge only when `setf_i` is 1 and the operation executes. Logical operations (opcodes 5 to 9) leave C and V unchanged.
- R6: ADC and SBC use the stored carry flag as carry-in. Two-word add chains (ADD with flags, then ADC) give exact 64-bit sums. Three-word subtract chains (SUB with flags, SBC with flags, SBC) give exact 96-bit differences.
- R7: When `cond_ok_i` is 0, `res_we_o` and `branch_o` stay 0 and the flags do not change.
- R8: When `base_is_pc_i` is 1, bits [1:0] of operand A are treated as 00.
- R9: When `base_is_pc_i` is 1 and `dst_is_pc_i` is 0, execution is legal only for ADD or SUB with `setf_i`=0, `imm_i`=1 and B no greater than 4095. Otherwise `illegal_o` is 1, and neither the result nor the flags are written.
- R10: When `dst_is_pc_i` is 1, execution is legal only for ADD with `imm_i`=0 and `setf_i`=0, and otherwise `illegal_o` is 1. A legal executed operation asserts `branch_o`, drives the result with bit 0 cleared on `target_o`, and keeps `res_we_o` at 0.
- R11: Opcodes 10 to 15 raise `illegal_o` and do not execute.
- R12: A synchronous active-high reset clears the flags to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | Base operand A |
| opb_i | input | 32 | Second operand B |
| setf_i | input | 1 | Update flags from this result |
| cond_ok_i | input | 1 | Instruction condition passed |
| imm_i | input | 1 | Operand B is an immediate |
| base_is_pc_i | input | 1 | Operand A is the program counter |
| dst_is_pc_i | input | 1 | Result is written to the program counter |
| res_o | output | 32 | Operation result |
| res_we_o | output | 1 | Result register write enable |
| branch_o | output | 1 | Branch-taken strobe |
| target_o | output | 32 | Branch target, bit 0 cleared |
| illegal_o | output | 1 | Illegal operand combination |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The hardest situation to reach from the ports is a stored carry crossing a word boundary in the middle of a multiword chain. The carry or borrow must be produced by one operation, held through a clock edge, and then consumed by the next. The stimulus builds two-word and three-word operands whose low words produce a carry or a borrow. It runs them as back-to-back flagged and unflagged steps, and compares the joined words with wide arithmetic worked out in the bench. Some chain steps have flags off on purpose, which shows that the carry they consume comes from an earlier step.

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int W = 32,
  parameter int IMM_MAX = 4095
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         setf_i,
  input  logic         cond_ok_i,
  input  logic         imm_i,
  input  logic         base_is_pc_i,
  input  logic         dst_is_pc_i,
  output logic [W-1:0] res_o,
  output logic         res_we_o,
  output logic         branch_o,
  output logic [W-1:0] target_o,
  output logic         illegal_o,
  output logic [3:0]   flags_o
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
                         OP_RSB = 4'd4, OP_AND = 4'd5, OP_ORR = 4'd6, OP_EOR = 4'd7,
                         OP_BIC = 4'd8, OP_ORN = 4'd9;

  logic [3:0]   flg_q;
  logic [W-1:0] base, ax, ay;
  logic         cin, is_arith, bad_op, bad_pc_dst, bad_pc_base, exec;
  logic [W:0]   sum;
  logic         c_new, v_new;

  assign base = base_is_pc_i ? {opa_i[W-1:2], 2'b00} : opa_i;

  always_comb begin
    ax = base;
    ay = opb_i;
    cin = 1'b0;
    is_arith = 1'b1;
    case (op_i)
      OP_ADD: ;
      OP_ADC: cin = flg_q[1];
      OP_SUB: begin ay = ~opb_i; cin = 1'b1; end
      OP_SBC: begin ay = ~opb_i; cin = flg_q[1]; end
      OP_RSB: begin ax = opb_i; ay = ~base; cin = 1'b1; end
      default: is_arith = 1'b0;
    endcase
  end

  assign sum   = {1'b0, ax} + {1'b0, ay} + {{W{1'b0}}, cin};
  assign c_new = is_arith ? sum[W] : flg_q[1];
  assign v_new = is_arith ? ((ax[W-1] == ay[W-1]) && (sum[W-1] != ax[W-1])) : flg_q[0];

  always_comb begin
    case (op_i)
      OP_AND:  res_o = base & opb_i;
      OP_ORR:  res_o = base | opb_i;
      OP_EOR:  res_o = base ^ opb_i;
      OP_BIC:  res_o = base & ~opb_i;
      OP_ORN:  res_o = base | ~opb_i;
      default: res_o = sum[W-1:0];
    endcase
  end

  assign bad_op      = (op_i > OP_ORN);
  assign bad_pc_dst  = dst_is_pc_i && !(op_i == OP_ADD && !imm_i && !setf_i);
  assign bad_pc_base = base_is_pc_i && !dst_is_pc_i &&
                       !((op_i == OP_ADD || op_i == OP_SUB) && !setf_i && imm_i &&
                         (opb_i <= W'(IMM_MAX)));
  assign illegal_o   = bad_op || bad_pc_dst || bad_pc_base;
  assign exec        = cond_ok_i && !illegal_o;

  assign res_we_o = exec && !dst_is_pc_i;
  assign branch_o = exec && dst_is_pc_i;
  assign target_o = {res_o[W-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) flg_q <= 4'b0000;
    else if (exec && setf_i) flg_q <= {res_o[W-1], (res_o == '0), c_new, v_new};
  end

  assign flags_o = flg_q;
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op_i,
  input logic         setf_i,
  input logic         cond_ok_i,
  input logic [W-1:0] res_o,
  input logic         res_we_o,
  input logic         branch_o,
  input logic [W-1:0] target_o,
  input logic         illegal_o,
  input logic [3:0]   flags_o
);
  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!setf_i || !cond_ok_i || illegal_o) |=> $stable(flags_o));

  assert_logic_keeps_cv_R5: assert property (@(posedge clk) disable iff (rst)
    (res_we_o && setf_i && op_i >= 4'd5) |=> (flags_o[1:0] == $past(flags_o[1:0])));

  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (res_we_o && setf_i) |=> (flags_o[2] == ($past(res_o) == '0)));

  assert_neg_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (res_we_o && setf_i) |=> (flags_o[3] == $past(res_o[W-1])));

  assert_cond_fail_R7: assert property (@(posedge clk) disable iff (rst)
    !cond_ok_i |-> (!res_we_o && !branch_o));

  assert_illegal_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!res_we_o && !branch_o));

  assert_target_even_R10: assert property (@(posedge clk) disable iff (rst)
    branch_o |-> (!target_o[0] && !res_we_o));

  assert_reset_clears_R12: assert property (@(posedge clk)
    rst |=> (flags_o == 4'b0000));
endmodule

bind int_exec_unit int_exec_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .setf_i(setf_i), .cond_ok_i(cond_ok_i),
  .res_o(res_o), .res_we_o(res_we_o), .branch_o(branch_o), .target_o(target_o),
  .illegal_o(illegal_o), .flags_o(flags_o)
);

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;
  logic clk = 1'b0, rst = 1'b1;
  logic [3:0] op = '0;
  logic [31:0] a = '0, b = '0;
  logic sf = 0, cp = 0, im = 0, bp = 0, dp = 0;
  logic [31:0] res, tgt;
  logic we, br, ill;
  logic [3:0] fl;
  int nchk = 0, nfail = 0;
  logic [3:0] ef = 4'b0000;
  logic [31:0] last_res;

  always #2 clk = ~clk;

  int_exec_unit u0 (.clk(clk), .rst(rst), .op_i(op), .opa_i(a), .opb_i(b), .setf_i(sf),
    .cond_ok_i(cp), .imm_i(im), .base_is_pc_i(bp), .dst_is_pc_i(dp), .res_o(res),
    .res_we_o(we), .branch_o(br), .target_o(tgt), .illegal_o(ill), .flags_o(fl));

  task automatic check(string tag, logic [95:0] act, logic [95:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [3:0] o, logic [31:0] x, logic [31:0] y,
                      logic s, logic c, logic i, logic pb, logic pd);
    logic [31:0] ea, r;
    logic cn, vn, legal, ex;
    longint sr;
    @(negedge clk);
    op = o; a = x; b = y; sf = s; cp = c; im = i; bp = pb; dp = pd;
    ea = pb ? (x & 32'hFFFF_FFFC) : x;
    cn = ef[1]; vn = ef[0]; sr = 0; r = '0;
    case (o)
      4'd0: begin r = ea + y; cn = ({1'b0, ea} + {1'b0, y}) > 33'hFFFF_FFFF;
              sr = longint'($signed(ea)) + longint'($signed(y)); end
      4'd1: begin r = ea + y + 32'(ef[1]); cn = ({1'b0, ea} + {1'b0, y} + 33'(ef[1])) > 33'hFFFF_FFFF;
              sr = longint'($signed(ea)) + longint'($signed(y)) + longint'(ef[1]); end
      4'd2: begin r = ea - y; cn = ea >= y;
              sr = longint'($signed(ea)) - longint'($signed(y)); end
      4'd3: begin r = ea - y - 32'(!ef[1]); cn = {1'b0, ea} >= ({1'b0, y} + 33'(!ef[1]));
              sr = longint'($signed(ea)) - longint'($signed(y)) - longint'(!ef[1]); end
      4'd4: begin r = y - ea; cn = y >= ea;
              sr = longint'($signed(y)) - longint'($signed(ea)); end
      4'd5: r = ea & y;
      4'd6: r = ea | y;
      4'd7: r = ea ^ y;
      4'd8: r = ea & ~y;
      4'd9: r = ea | ~y;
      default: r = '0;
    endcase
    if (o <= 4'd4) vn = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    legal = (o <= 4'd9);
    if (pd) legal = legal && o == 4'd0 && !i && !s;
    else if (pb) legal = legal && (o == 4'd0 || o == 4'd2) && !s && i && y <= 32'd4095;
    ex = legal && c;
    #1;
    check({tag, " illegal"}, 96'(ill), 96'(!legal));
    check({tag, " write enable"}, 96'(we), 96'(ex && !pd));
    check({tag, " branch"}, 96'(br), 96'(ex && pd));
    if (ex && !pd) check({tag, " result"}, 96'(res), 96'(r));
    if (ex && pd) check({tag, " target"}, 96'(tgt), 96'(r & 32'hFFFF_FFFE));
    last_res = res;
    if (ex && s) ef = {r[31], r == 0, cn, vn};
    @(posedge clk); #1;
    check({tag, " flags"}, 96'(fl), 96'(ef));
  endtask

  task automatic t_reset;
    rst = 1; repeat (2) @(posedge clk); #1;
    ef = 0;
    check("R12 reset flags", 96'(fl), 96'(4'b0000));
    @(negedge clk); rst = 0;
  endtask

  task automatic t_arith;
    step("R1 ADD", 0, 32'h1234_5678, 32'h1111_1111, 1, 1, 0, 0, 0);
    step("R3 ADD carry+zero R4", 0, 32'hFFFF_FFFF, 32'h1, 1, 1, 0, 0, 0);
    step("R3 ADD signed overflow", 0, 32'h7FFF_FFFF, 32'h1, 1, 1, 0, 0, 0);
    step("R3 SUB no borrow", 2, 32'd10, 32'd3, 1, 1, 0, 0, 0);
    step("R3 SUB borrow N R4", 2, 32'd3, 32'd10, 1, 1, 0, 0, 0);
    step("R3 SUB overflow", 2, 32'h8000_0000, 32'h1, 1, 1, 0, 0, 0);
    step("R2 RSB", 4, 32'd4, 32'd1280, 1, 1, 1, 0, 0);
    step("R2 RSB borrow", 4, 32'd9, 32'd2, 1, 1, 0, 0, 0);
    step("R5 no setf ADD", 0, 32'h0, 32'h0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_logic;
    step("R3 seed carry", 0, 32'hFFFF_FFFF, 32'h2, 1, 1, 0, 0, 0);
    step("R1 AND R5", 5, 32'hF0F0_1234, 32'h0FF0_FFFF, 1, 1, 0, 0, 0);
    step("R1 ORR", 6, 32'h8000_0000, 32'h1, 1, 1, 0, 0, 0);
    step("R1 EOR zero", 7, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1, 1, 0, 0, 0);
    step("R1 BIC", 8, 32'hFFFF_00FF, 32'h0000_000F, 1, 1, 0, 0, 0);
    step("R1 ORN", 9, 32'h0000_0000, 32'hFFFF_0000, 1, 1, 0, 0, 0);
  endtask

  task automatic t_chain;
    logic [63:0] x64, y64, hi_lo;
    logic [95:0] x96, y96, d96;
    logic [31:0] w0, w1;
    x64 = 64'h0000_0001_FFFF_FFFF; y64 = 64'h0000_0002_0000_0001;
    step("R6 ADDS low", 0, x64[31:0], y64[31:0], 1, 1, 0, 0, 0); w0 = last_res;
    step("R6 ADC high", 1, x64[63:32], y64[63:32], 0, 1, 0, 0, 0);
    hi_lo = {last_res, w0};
    check("R6 64-bit sum", 96'(hi_lo), 96'(x64 + y64));
    x96 = 96'h0000_0005_0000_0000_0000_0001; y96 = 96'h0000_0001_0000_0001_0000_0002;
    step("R6 SUBS low", 2, x96[31:0], y96[31:0], 1, 1, 0, 0, 0); w0 = last_res;
    step("R6 SBCS mid", 3, x96[63:32], y96[63:32], 1, 1, 0, 0, 0); w1 = last_res;
    step("R6 SBC high", 3, x96[95:64], y96[95:64], 0, 1, 0, 0, 0);
    d96 = {last_res, w1, w0};
    check("R6 96-bit difference", d96, x96 - y96);
  endtask

  task automatic t_cond;
    step("R7 condition fail", 0, 32'h0, 32'h0, 1, 0, 0, 0, 0);
    step("R7 condition fail pc", 0, 32'h100, 32'h3, 0, 0, 0, 0, 1);
  endtask

  task automatic t_pc;
    step("R8 PC base ADD", 0, 32'h0000_1003, 32'h10, 0, 1, 1, 1, 0);
    step("R8 PC base SUB", 2, 32'h0000_1002, 32'h4, 0, 1, 1, 1, 0);
    step("R9 PC imm too big", 0, 32'h1000, 32'd4096, 0, 1, 1, 1, 0);
    step("R9 PC base with setf", 0, 32'h1000, 32'd4, 1, 1, 1, 1, 0);
    step("R9 PC base ADC", 1, 32'h1000, 32'd4, 0, 1, 1, 1, 0);
    step("R9 PC base register", 2, 32'h1000, 32'd4, 0, 1, 0, 1, 0);
    step("R9 PC base max imm", 0, 32'h2000, 32'd4095, 0, 1, 1, 1, 0);
    step("R10 PC dest ADD", 0, 32'h0000_0100, 32'h35, 0, 1, 0, 0, 1);
    step("R10 ADD PC,PC,Rm", 0, 32'h0000_0203, 32'h11, 0, 1, 0, 1, 1);
    step("R10 PC dest setf", 0, 32'h100, 32'h1, 1, 1, 0, 0, 1);
    step("R10 PC dest SUB", 2, 32'h100, 32'h1, 0, 1, 0, 0, 1);
  endtask

  task automatic t_badop;
    step("R11 opcode 10", 4'd10, 32'h1, 32'h1, 1, 1, 0, 0, 0);
    step("R11 opcode 15", 4'd15, 32'h0, 32'h0, 1, 1, 0, 0, 0);
  endtask

  task automatic t_reset_mid;
    step("R12 set flags", 2, 32'd1, 32'd2, 1, 1, 0, 0, 0);
    t_reset();
  endtask

  initial begin
    t_reset();
    t_arith();
    t_logic();
    t_chain();
    t_cond();
    t_pc();
    t_badop();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule